// File: doc/BRIEF.md
# Switchable-Ratio Audio Interpolation Filter

This block raises the sample rate of a stereo audio stream ahead of a sigma-delta modulator. Each input strobe delivers one left and one right 16-bit sample. An optional first-order shelving IIR de-emphasis filter processes them first. A cascade of half-band ×2 interpolators then raises the rate. In standard speed three stages (43, 11 and 3 taps, in that order) give eight output pairs per input pair. In double speed the input strobes come twice as often on the same master clock, so the 11-tap stage is skipped and four output pairs are produced per input pair.

The master clock runs at 384 times the standard sample rate. Each interpolator owns one multiplier-accumulator. It serves the left and right channels in alternating cycles and exploits coefficient symmetry by summing mirrored taps before the multiply. Every stage emits the sample it received unchanged on one phase and the filtered midpoint on the other. All samples inside the chain are 20-bit signed. The 16-bit input enters at bits 19:4.

The speed and de-emphasis selections are taken while reset is low. They stay fixed until the next reset, so one run never mixes the state of two configurations.

Top module: `interp_chain`

## Requirements
- R1: In standard speed (double_speed low at reset), every input strobe produces exactly eight out_valid pulses. A linear ramp of input step s (de-emphasis off) settles to an output step of exactly 2·s (that is, s·16/8).
- R2: In double speed (double_speed high at reset), every input strobe produces exactly four out_valid pulses. A ramp of input step s settles to an output step of exactly 4·s.
- R3: In double speed the middle (11-tap) stage never emits a sample.
- R4: Each ×2 stage passes its input samples through unchanged on alternate outputs. With de-emphasis off, an input alternating between +A and −A therefore reaches a settled output peak of exactly 16·A.
- R5: With de-emphasis off, a constant input c settles to an output of exactly 16·c on both channels.
- R6: With de-emphasis on (deemph_on high at reset), a constant input c settles to within ±8 of 16·c. An input alternating between +A and −A settles to an output peak magnitude below 8·A.
- R7: With de-emphasis off, the front stage outputs its input shifted left by four bits, one cycle after the strobe.
- R8: Changes of double_speed or deemph_on while rst_n is high have no effect on output count or output values.
- R9: While rst_n is low, out_valid is low and out_left is zero. Reset clears all filter state, so an all-zero input afterwards gives all-zero outputs.
- R10: Each stage completes its work before its next input arrives. Consecutive out_valid pulses are never back to back.
- R11: After reset, out_valid stays low until an input strobe has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 384× the standard sample rate |
| rst_n | input | 1 | Active-low reset; mode inputs sampled while low |
| deemph_on | input | 1 | 1 selects de-emphasis |
| double_speed | input | 1 | 1 selects double speed (4× ratio) |
| in_valid | input | 1 | One-cycle strobe for a new input pair |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| out_valid | output | 1 | Output pair valid |
| out_left | output | 20 | Left output sample, signed |
| out_right | output | 20 | Right output sample, signed |

## Verification
An input strobe reaches the front stage one cycle later. A stage with h half-taps then emits its pass-through sample two cycles after it accepts a sample, and its interpolated sample 2h+1 cycles after that. All outputs of one input pair are therefore out within about 60 cycles, far inside the 192-cycle double-speed frame. The bench spaces strobes a full frame apart (384 or 192 cycles) and records every out_valid pulse at the falling edge. It compares counts and values only after one more idle frame, so no check depends on the exact cycle of any single output. Ramp, constant and alternating patterns are judged only on the final outputs, once the longest delay line holds nothing but post-start samples.

// File: rtl/interp_pkg.sv
package interp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PASS,
      ST_MAC,
      ST_EMIT
   } stage_st_t;

   // one side of the symmetric kernel at distance i from the midpoint
   function automatic int hb_side(input int frac, input int i);
      int mag;
      mag = (2 * i < 14) ? ((1 << (frac - 2)) >> (2 * i)) : 0;
      return (i % 2 == 1) ? -mag : mag;
   endfunction

   // half-band interpolation coefficient; the side set sums to one half
   function automatic int hb_coef(input int frac, input int half, input int k);
      int s;
      s = 0;
      if (k != 0) return hb_side(frac, k);
      for (int i = 1; i < half; i++) s += hb_side(frac, i);
      return (1 << (frac - 1)) - s;
   endfunction

endpackage

// File: rtl/deemph_iir.sv
module deemph_iir #(
   parameter int IN_W   = 16,
   parameter int DATA_W = 20,
   parameter int COEF_W = 18,
   parameter int ACC_W  = 40,
   parameter int FRAC   = 15,
   parameter int B0     = 15073,
   parameter int LEAK   = 17039
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     in_valid,
   input  logic signed [IN_W-1:0]   in_l,
   input  logic signed [IN_W-1:0]   in_r,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_l,
   output logic signed [DATA_W-1:0] out_r
);
   localparam int SH = DATA_W - IN_W;
   localparam logic signed [ACC_W-1:0]  RND  = ACC_W'(1) <<< (FRAC - 1);
   localparam logic signed [ACC_W-1:0]  MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - 1;
   localparam logic signed [ACC_W-1:0]  MINV = -MAXV - 1;
   localparam logic signed [COEF_W-1:0] K_B0 = COEF_W'(B0);
   localparam logic signed [COEF_W-1:0] K_LK = COEF_W'(LEAK);

   if (SH < 1) begin : g_bad_width
      $error("deemph_iir: DATA_W must exceed IN_W");
   end

   logic valid_q;

   for (genvar g = 0; g < 2; g++) begin : g_ch
      logic signed [IN_W-1:0]   raw;
      logic signed [DATA_W-1:0] x, x1_q, y1_q, y_sat, res_q;
      logic signed [DATA_W:0]   d_in, d_fb;
      logic signed [ACC_W-1:0]  sum, y_wide;

      assign raw  = (g == 0) ? in_l : in_r;
      assign x    = {raw, {SH{1'b0}}};
      assign d_in = {x[DATA_W-1], x} - {x1_q[DATA_W-1], x1_q};
      assign d_fb = {x1_q[DATA_W-1], x1_q} - {y1_q[DATA_W-1], y1_q};

      always_comb begin
         sum    = ACC_W'(K_B0 * d_in) + ACC_W'(K_LK * d_fb) + RND;
         y_wide = ACC_W'(y1_q) + (sum >>> FRAC);
         if (y_wide > MAXV)      y_sat = MAXV[DATA_W-1:0];
         else if (y_wide < MINV) y_sat = MINV[DATA_W-1:0];
         else                    y_sat = y_wide[DATA_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            x1_q  <= '0;
            y1_q  <= '0;
            res_q <= '0;
         end else if (in_valid) begin
            x1_q  <= x;
            y1_q  <= y_sat;
            res_q <= enable ? y_sat : x;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= in_valid;
   end

   assign out_valid = valid_q;
   assign out_l     = g_ch[0].res_q;
   assign out_r     = g_ch[1].res_q;

   // R7
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !enable) |-> (out_l == $signed({$past(in_l), {SH{1'b0}}})));

endmodule

// File: rtl/x2_stage.sv
module x2_stage
   import interp_pkg::*;
#(
   parameter int HALF   = 11,
   parameter int DATA_W = 20,
   parameter int COEF_W = 18,
   parameter int ACC_W  = 40,
   parameter int FRAC   = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_l,
   input  logic signed [DATA_W-1:0] in_r,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_l,
   output logic signed [DATA_W-1:0] out_r
);
   localparam int LINE  = 2 * HALF;
   localparam int IW    = (LINE > 1) ? $clog2(LINE) : 1;
   localparam int DEPTH = 1 << IW;
   localparam int KW    = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int PW    = COEF_W + DATA_W + 1;
   localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC - 1);
   localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - 1;
   localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;

   if (HALF < 1) begin : g_bad_half
      $error("x2_stage: HALF must be at least 1");
   end
   if (ACC_W < PW + 1) begin : g_bad_acc
      $error("x2_stage: ACC_W too narrow for the product");
   end

   logic signed [COEF_W-1:0] coef [1 << KW];
   for (genvar g = 0; g < (1 << KW); g++) begin : g_coef
      if (g < HALF) begin : g_used
         assign coef[g] = COEF_W'(hb_coef(FRAC, HALF, g));
      end else begin : g_pad
         assign coef[g] = '0;
      end
   end

   stage_st_t               st;
   logic [IW-1:0]           j;
   logic signed [DATA_W-1:0] line_l [DEPTH];
   logic signed [DATA_W-1:0] line_r [DEPTH];
   logic signed [ACC_W-1:0] acc_l, acc_r;
   logic [IW-1:0]           ia, ib;
   logic [KW-1:0]           kc;
   logic signed [DATA_W:0]  pair;
   logic signed [PW-1:0]    prod;

   function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] a);
      logic signed [ACC_W-1:0] s;
      s = (a + RND) >>> FRAC;
      if (s > MAXV) return MAXV[DATA_W-1:0];
      if (s < MINV) return MINV[DATA_W-1:0];
      return s[DATA_W-1:0];
   endfunction

   always_comb begin
      kc = KW'(j >> 1);
      ia = IW'(HALF - 1) - IW'(j >> 1);
      ib = IW'(HALF) + IW'(j >> 1);
      if (j[0] == 1'b0)
         pair = {line_l[ia][DATA_W-1], line_l[ia]} + {line_l[ib][DATA_W-1], line_l[ib]};
      else
         pair = {line_r[ia][DATA_W-1], line_r[ia]} + {line_r[ib][DATA_W-1], line_r[ib]};
      prod = coef[kc] * pair;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         j     <= '0;
         acc_l <= '0;
         acc_r <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            line_l[i] <= '0;
            line_r[i] <= '0;
         end
      end else begin
         case (st)
            ST_IDLE: if (in_valid) begin
               for (int i = DEPTH - 1; i > 0; i--) begin
                  line_l[i] <= line_l[i-1];
                  line_r[i] <= line_r[i-1];
               end
               line_l[0] <= in_l;
               line_r[0] <= in_r;
               st        <= ST_PASS;
            end
            ST_PASS: begin
               j     <= '0;
               acc_l <= '0;
               acc_r <= '0;
               st    <= ST_MAC;
            end
            ST_MAC: begin
               if (j[0] == 1'b0) acc_l <= acc_l + ACC_W'(prod);
               else              acc_r <= acc_r + ACC_W'(prod);
               j <= j + 1'b1;
               if (j == IW'(LINE - 1)) st <= ST_EMIT;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign out_valid = (st == ST_PASS) || (st == ST_EMIT);
   assign out_l     = (st == ST_PASS) ? line_l[HALF] : rnd_sat(acc_l);
   assign out_r     = (st == ST_PASS) ? line_r[HALF] : rnd_sat(acc_r);

   // R10
   overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (st == ST_IDLE));

endmodule

// File: rtl/interp_chain.sv
module interp_chain #(
   parameter int IN_W       = 16,
   parameter int DATA_W     = 20,
   parameter int COEF_W     = 18,
   parameter int ACC_W      = 40,
   parameter int FRAC       = 15,
   parameter int HALF_A     = 11,
   parameter int HALF_B     = 3,
   parameter int HALF_C     = 1,
   parameter bit HAS_DEEMPH = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     deemph_on,
   input  logic                     double_speed,
   input  logic                     in_valid,
   input  logic signed [IN_W-1:0]   in_left,
   input  logic signed [IN_W-1:0]   in_right,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_left,
   output logic signed [DATA_W-1:0] out_right
);
   localparam int SH = DATA_W - IN_W;

   if (ACC_W < 32) begin : g_bad_acc
      $error("interp_chain: ACC_W must be at least 32");
   end
   if (SH < 1) begin : g_bad_w
      $error("interp_chain: DATA_W must exceed IN_W");
   end

   logic dbl_q, de_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dbl_q <= double_speed;
         de_q  <= deemph_on;
      end
   end

   logic                     f_valid;
   logic signed [DATA_W-1:0] f_l, f_r;

   if (HAS_DEEMPH) begin : g_de
      deemph_iir #(
         .IN_W(IN_W), .DATA_W(DATA_W), .COEF_W(COEF_W),
         .ACC_W(ACC_W), .FRAC(FRAC)
      ) i_de (
         .clk(clk), .rst_n(rst_n), .enable(de_q), .in_valid(in_valid),
         .in_l(in_left), .in_r(in_right),
         .out_valid(f_valid), .out_l(f_l), .out_r(f_r)
      );
   end else begin : g_plain
      logic                     v_q;
      logic signed [DATA_W-1:0] l_q, r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            l_q <= '0;
            r_q <= '0;
         end else begin
            v_q <= in_valid;
            if (in_valid) begin
               l_q <= {in_left, {SH{1'b0}}};
               r_q <= {in_right, {SH{1'b0}}};
            end
         end
      end
      assign f_valid = v_q;
      assign f_l     = l_q;
      assign f_r     = r_q;
   end

   logic                     a_valid, b_valid, c_in_valid;
   logic signed [DATA_W-1:0] a_l, a_r, b_l, b_r, c_in_l, c_in_r;

   x2_stage #(.HALF(HALF_A), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(FRAC)) i_st_a (
      .clk(clk), .rst_n(rst_n), .in_valid(f_valid), .in_l(f_l), .in_r(f_r),
      .out_valid(a_valid), .out_l(a_l), .out_r(a_r)
   );

   x2_stage #(.HALF(HALF_B), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(FRAC)) i_st_b (
      .clk(clk), .rst_n(rst_n), .in_valid(a_valid && !dbl_q), .in_l(a_l), .in_r(a_r),
      .out_valid(b_valid), .out_l(b_l), .out_r(b_r)
   );

   assign c_in_valid = dbl_q ? a_valid : b_valid;
   assign c_in_l     = dbl_q ? a_l : b_l;
   assign c_in_r     = dbl_q ? a_r : b_r;

   x2_stage #(.HALF(HALF_C), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(FRAC)) i_st_c (
      .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_l(c_in_l), .in_r(c_in_r),
      .out_valid(out_valid), .out_l(out_left), .out_r(out_right)
   );

   logic seen_in;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_in <= 1'b0;
      else if (in_valid) seen_in <= 1'b1;
   end

   // R3
   mid_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbl_q |-> !b_valid);

   // R11
   no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> seen_in);

   // R10
   out_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

// File: tb/test_interp_chain.sv
module test_interp_chain;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic deemph_on = 1'b0, double_speed = 1'b0, in_valid = 1'b0;
   logic signed [15:0] in_left = '0, in_right = '0;
   logic out_valid;
   logic signed [19:0] out_left, out_right;

   int n_chk = 0, n_bad = 0, n_out = 0;
   int o_l [1024];
   int o_r [1024];

   always #10 clk = ~clk;

   interp_chain i_interp_chain (
      .clk(clk), .rst_n(rst_n), .deemph_on(deemph_on), .double_speed(double_speed),
      .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
      .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && n_out < 1024) begin
         o_l[n_out] = int'(out_left);
         o_r[n_out] = int'(out_right);
         n_out++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic dbl, input logic de);
      @(negedge clk);
      rst_n = 1'b0;
      double_speed = dbl;
      deemph_on = de;
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      n_out = 0;
   endtask

   task automatic send(input int l, input int r, input int period);
      @(negedge clk);
      in_valid = 1'b1;
      in_left  = 16'(l);
      in_right = 16'(r);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (period - 2) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
      check(out_left == '0, "R9 out_left in reset", int'(out_left), 0);
      do_reset(1'b0, 1'b0);
      repeat (1000) @(negedge clk);
      check(n_out == 0, "R11 no output before input", n_out, 0);
   endtask

   task automatic t_ramp_std;
      int bad;
      do_reset(1'b0, 1'b0);
      for (int f = 0; f < 40; f++) send(f * 64, -f * 64, 384);
      repeat (384) @(negedge clk);
      check(n_out == 320, "R1 eight outputs per input", n_out, 320);
      bad = 0;
      for (int i = n_out - 64; i < n_out; i++) begin
         if (o_l[i] - o_l[i-1] != 128) begin
            bad++;
            check(1'b0, "R1 left ramp step", o_l[i] - o_l[i-1], 128);
         end
         if (o_r[i] - o_r[i-1] != -128) begin
            bad++;
            check(1'b0, "R1 right ramp step", o_r[i] - o_r[i-1], -128);
         end
      end
      check(bad == 0, "R1 ramp steps", bad, 0);
   endtask

   task automatic t_ramp_dbl;
      int bad;
      do_reset(1'b1, 1'b0);
      // R10: fastest input rate keeps every stage within its budget
      for (int f = 0; f < 40; f++) send(f * 64, -f * 64, 192);
      repeat (192) @(negedge clk);
      check(n_out == 160, "R2 four outputs per input (R3 middle stage skipped)", n_out, 160);
      bad = 0;
      for (int i = n_out - 48; i < n_out; i++) begin
         if (o_l[i] - o_l[i-1] != 256 || o_r[i] - o_r[i-1] != -256) begin
            bad++;
            check(1'b0, "R2 ramp step", o_l[i] - o_l[i-1], 256);
         end
      end
      check(bad == 0, "R2 ramp steps", bad, 0);
   endtask

   task automatic t_mode_hold;
      do_reset(1'b0, 1'b0);
      for (int f = 0; f < 30; f++) begin
         if (f == 10) begin
            double_speed = 1'b1;
            deemph_on = 1'b1;
         end
         send(500, -300, 384);
      end
      repeat (384) @(negedge clk);
      check(n_out == 240, "R8 output count unchanged", n_out, 240);
      check(o_l[n_out-1] == 8000, "R8 left value unchanged", o_l[n_out-1], 8000);
      check(o_r[n_out-1] == -4800, "R8 right value unchanged", o_r[n_out-1], -4800);
   endtask

   task automatic t_dc;
      int bad;
      // R5, R7: de-emphasis off leaves the constant exact
      do_reset(1'b0, 1'b0);
      for (int f = 0; f < 30; f++) send(1000, -700, 384);
      repeat (384) @(negedge clk);
      bad = 0;
      for (int i = n_out - 16; i < n_out; i++)
         if (o_l[i] != 16000 || o_r[i] != -11200) bad++;
      check(bad == 0, "R5 constant exact", o_l[n_out-1], 16000);
      check(o_r[n_out-1] == -11200, "R7 right constant exact", o_r[n_out-1], -11200);
      do_reset(1'b0, 1'b1);
      for (int f = 0; f < 30; f++) send(1000, -700, 384);
      repeat (384) @(negedge clk);
      bad = 0;
      for (int i = n_out - 16; i < n_out; i++)
         if (o_l[i] > 16008 || o_l[i] < 15992 || o_r[i] > -11192 || o_r[i] < -11208) bad++;
      check(bad == 0, "R6 de-emphasis constant", o_l[n_out-1], 16000);
   endtask

   task automatic t_nyq;
      int pk;
      do_reset(1'b0, 1'b0);
      for (int f = 0; f < 30; f++) send((f % 2 == 0) ? 8000 : -8000, (f % 2 == 0) ? -8000 : 8000, 384);
      repeat (384) @(negedge clk);
      pk = 0;
      for (int i = n_out - 64; i < n_out; i++) if ((o_l[i] < 0 ? -o_l[i] : o_l[i]) > pk) pk = (o_l[i] < 0 ? -o_l[i] : o_l[i]);
      check(pk == 128000, "R4 pass-through peak", pk, 128000);
      do_reset(1'b0, 1'b1);
      for (int f = 0; f < 30; f++) send((f % 2 == 0) ? 8000 : -8000, (f % 2 == 0) ? -8000 : 8000, 384);
      repeat (384) @(negedge clk);
      pk = 0;
      for (int i = n_out - 64; i < n_out; i++) if ((o_r[i] < 0 ? -o_r[i] : o_r[i]) > pk) pk = (o_r[i] < 0 ? -o_r[i] : o_r[i]);
      check(pk < 64000, "R6 de-emphasis high-band cut", pk, 63999);
   endtask

   task automatic t_clear;
      int bad;
      do_reset(1'b0, 1'b0);
      for (int f = 0; f < 12; f++) send(0, 0, 384);
      repeat (384) @(negedge clk);
      check(n_out == 96, "R9 count after reset", n_out, 96);
      bad = 0;
      for (int i = 0; i < n_out; i++) if (o_l[i] != 0 || o_r[i] != 0) bad++;
      check(bad == 0, "R9 state cleared", bad, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_ramp_std();
      t_ramp_dbl();
      t_mode_hold();
      t_dc();
      t_nyq();
      t_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule